// File: doc/BRIEF.md
# Precision Gamma Palette with Auto-Increment Loading

This block holds a per-channel gamma table for a display pipe. Every table entry is one word with three 10-bit color codes. Software fills the table through two registers. A control register sets the load pointer, an auto-advance flag and a split flag. A data port stores one packed word at the pointer. Three 16-bit ceiling registers, one for each channel, set the output for pixel inputs at or above 1.0.

On the pixel side, each channel carries its own 11-bit input. The top bit of that input marks a value that is out of range. For an in-range value, the channel's upper input bits address the table. The result is one clock later, left-aligned in a 16-bit field. An out-of-range channel returns its ceiling register instead.

In split mode the table is two halves. The lower half is the degamma section and the upper half is the gamma section. The load pointer then wraps within its own half, and pixel lookups read only the upper half. When both control flags are clear, the block reports that the legacy palette path is selected.

Top module: `prec_gamma_lut`

## Requirements
- R1: After reset, table entry i holds floor(i*1023/(DEPTH-1)) in all three channel fields (DEPTH=256 by default). All three ceiling registers reset to 0xFFFF, the load pointer resets to 0, and both control flags reset to 0.
- R2: A data word packs red in bits 29:20, green in bits 19:10 and blue in bits 9:0. The pixel output places red in bits 47:32, green in bits 31:16 and blue in bits 15:0. Each output field is the 10-bit entry code followed by six zero bits.
- R3: When the auto-advance flag (control bit 15) is set, a data write stores at the pointer, and the pointer then moves to the next entry.
- R4: When the auto-advance flag is clear, a data write stores at the pointer and the pointer does not move, so repeated writes replace the same entry.
- R5: With split mode off, advancing from entry DEPTH-1 wraps the pointer to entry 0.
- R6: With split mode on (control bit 14), the pointer wraps inside its own half. Entry DEPTH/2-1 advances to 0, and entry DEPTH-1 advances to DEPTH/2.
- R7: With split mode on, an in-range channel value v reads entry DEPTH/2 + (v >> (10-AW+1)). With the defaults, that is 128 + (v >> 3).
- R8: With split mode off, an in-range channel value v reads entry v >> (10-AW). With the defaults, that is v >> 2.
- R9: A control write loads the pointer from bits AW-1:0 and the flags from bits 15 and 14. The output legacy_en is high exactly when both flags are clear, so a control write of zero selects the legacy path.
- R10: A channel whose input bit 10 is set outputs that channel's 16-bit ceiling register, whatever the other channels are doing.
- R11: A ceiling write with selector 2 updates red, selector 1 updates green and selector 0 updates blue. A write with selector 3 changes none of the ceiling registers.
- R12: Pixel results and pix_vld_out appear exactly one clock after the pixel input and pix_vld_in are presented.
- R13: When a data write and a lookup hit the same entry in the same cycle, the lookup returns the entry's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_wr | input | 1 | Write strobe for the control register |
| idx_wdata | input | 16 | Control value: bit 15 auto-advance, bit 14 split, bits AW-1:0 pointer |
| dat_wr | input | 1 | Write strobe for the data port |
| dat_wdata | input | 3*CW | Packed entry word |
| max_wr | input | 1 | Write strobe for a ceiling register |
| max_sel | input | 2 | Ceiling selector (2 red, 1 green, 0 blue, 3 none) |
| max_wdata | input | MW | Ceiling value |
| pix_vld_in | input | 1 | Pixel input qualifier |
| pix_in | input | 3*(CW+1) | Pixel input, red/green/blue, each with an out-of-range bit on top |
| pix_vld_out | output | 1 | Pixel output qualifier |
| pix_out | output | 3*MW | Looked-up pixel, red/green/blue |
| legacy_en | output | 1 | High when both control flags are clear |

## Verification
The hardest case to reach is the pointer wrapping inside a half in split mode. Reaching it needs a control write that places the pointer one entry before each half boundary. The stimulus then makes several auto-advance writes and reads the results back through split-mode lookups. Those lookups can only see the upper half, so the lower-half wrap is checked afterwards: the bench returns to unsplit mode and looks up entry 0. Same-cycle collisions are reached by asserting a data write and a lookup of that entry in one cycle.

// File: rtl/prec_gamma_pkg.sv
package prec_gamma_pkg;

   localparam int unsigned IDX_REG_W = 16;
   localparam int unsigned AINC_POS  = 15;
   localparam int unsigned SPLIT_POS = 14;
   localparam int unsigned NUM_CH    = 3;

   typedef enum logic [1:0] {
      CH_BLUE  = 2'd0,
      CH_GREEN = 2'd1,
      CH_RED   = 2'd2,
      CH_NONE  = 2'd3
   } chan_sel_e;

   typedef struct packed {
      logic ainc;
      logic split;
   } idx_ctrl_t;

   // evenly spaced code for entry i of a table with depth entries
   function automatic int unsigned lin_code(input int unsigned i,
                                            input int unsigned depth,
                                            input int unsigned full);
      return (i * full) / (depth - 1);
   endfunction

endpackage

// File: rtl/pal_index_ctrl.sv
module pal_index_ctrl
   import prec_gamma_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idx_wr,
   input  logic [IDX_REG_W-1:0] idx_wdata,
   input  logic                 dat_wr,
   output logic [AW-1:0]        idx_q,
   output idx_ctrl_t            ctrl_q
);

   logic [AW-1:0] idx_nxt;
   logic [AW-2:0] low_inc;
   logic          unused_hi_bits;

   assign unused_hi_bits = ^idx_wdata[SPLIT_POS-1:AW];
   assign low_inc        = idx_q[AW-2:0] + 1'b1;

   // split mode keeps the half-select bit, full mode wraps over the whole table
   always_comb begin
      if (ctrl_q.split) idx_nxt = {idx_q[AW-1], low_inc};
      else              idx_nxt = idx_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         ctrl_q <= '0;
      end else if (idx_wr) begin
         idx_q        <= idx_wdata[AW-1:0];
         ctrl_q.ainc  <= idx_wdata[AINC_POS];
         ctrl_q.split <= idx_wdata[SPLIT_POS];
      end else if (dat_wr && ctrl_q.ainc) begin
         idx_q <= idx_nxt;
      end
   end

endmodule

// File: rtl/pal_store.sv
module pal_store
   import prec_gamma_pkg::*;
#(
   parameter int unsigned CW = 10,
   parameter int unsigned AW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [NUM_CH*CW-1:0]   wr_data,
   input  logic [NUM_CH*AW-1:0]   rd_addr,
   output logic [NUM_CH*CW-1:0]   rd_data
);

   localparam int unsigned DEPTH   = 1 << AW;
   localparam int unsigned ENTRY_W = NUM_CH * CW;
   localparam int unsigned FULL    = (1 << CW) - 1;

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= {NUM_CH{CW'(lin_code(i, DEPTH, FULL))}};
         end
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // one registered read port per channel, each returning its own field
   for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
      logic [CW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= mem[rd_addr[c*AW +: AW]][c*CW +: CW];
      end
      assign rd_data[c*CW +: CW] = q;
   end

endmodule

// File: rtl/pal_range_clamp.sv
module pal_range_clamp
   import prec_gamma_pkg::*;
#(
   parameter int unsigned CW = 10,
   parameter int unsigned MW = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      max_wr,
   input  logic [1:0]                max_sel,
   input  logic [MW-1:0]             max_wdata,
   input  logic [NUM_CH*(CW+1)-1:0]  pix_in,
   input  logic [NUM_CH*CW-1:0]      lut_q,
   output logic [NUM_CH*MW-1:0]      pix_out,
   output logic [NUM_CH*MW-1:0]      max_flat
);

   localparam int unsigned PAD = MW - CW;
   localparam int unsigned PW  = CW + 1;

   chan_sel_e sel;
   assign sel = chan_sel_e'(max_sel);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [MW-1:0] max_r;
      logic [MW-1:0] snap;
      logic          ovr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   max_r <= '1;
         else if (max_wr && (sel == chan_sel_e'(c)))   max_r <= max_wdata;
      end

      // capture the over-range flag and ceiling alongside the table read
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ovr  <= 1'b0;
            snap <= '0;
         end else begin
            ovr  <= pix_in[c*PW + CW];
            snap <= max_r;
         end
      end

      assign pix_out[c*MW +: MW]  = ovr ? snap : {lut_q[c*CW +: CW], {PAD{1'b0}}};
      assign max_flat[c*MW +: MW] = max_r;
   end

endmodule

// File: rtl/prec_gamma_lut.sv
module prec_gamma_lut
   import prec_gamma_pkg::*;
#(
   parameter int unsigned CW = 10,
   parameter int unsigned AW = 8,
   parameter int unsigned MW = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      idx_wr,
   input  logic [15:0]               idx_wdata,
   input  logic                      dat_wr,
   input  logic [3*CW-1:0]           dat_wdata,
   input  logic                      max_wr,
   input  logic [1:0]                max_sel,
   input  logic [MW-1:0]             max_wdata,
   input  logic                      pix_vld_in,
   input  logic [3*(CW+1)-1:0]       pix_in,
   output logic                      pix_vld_out,
   output logic [3*MW-1:0]           pix_out,
   output logic                      legacy_en
);

   localparam int unsigned PW = CW + 1;

   if (AW < 2) begin : g_bad_aw_small
      $error("prec_gamma_lut: AW must be at least 2");
   end
   if (AW > CW) begin : g_bad_aw_cw
      $error("prec_gamma_lut: AW must not exceed CW");
   end
   if (AW >= SPLIT_POS) begin : g_bad_aw_field
      $error("prec_gamma_lut: pointer must fit below the control flags");
   end
   if (MW <= CW) begin : g_bad_mw
      $error("prec_gamma_lut: MW must exceed CW");
   end

   logic [AW-1:0]        idx_q;
   idx_ctrl_t            ctrl_q;
   logic [NUM_CH*AW-1:0] rd_addr;
   logic [NUM_CH*CW-1:0] lut_q;
   logic [NUM_CH*MW-1:0] max_flat;
   logic                 vld_q;

   pal_index_ctrl #(.AW(AW)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .idx_wdata (idx_wdata),
      .dat_wr    (dat_wr),
      .idx_q     (idx_q),
      .ctrl_q    (ctrl_q)
   );

   // split mode: upper half only, using the top AW-1 bits of the value
   for (genvar c = 0; c < NUM_CH; c++) begin : g_addr
      assign rd_addr[c*AW +: AW] = ctrl_q.split
         ? {1'b1, pix_in[c*PW + CW - 1 -: AW - 1]}
         : pix_in[c*PW + CW - 1 -: AW];
   end

   pal_store #(.CW(CW), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dat_wr),
      .wr_addr (idx_q),
      .wr_data (dat_wdata),
      .rd_addr (rd_addr),
      .rd_data (lut_q)
   );

   pal_range_clamp #(.CW(CW), .MW(MW)) u_clamp (
      .clk       (clk),
      .rst_n     (rst_n),
      .max_wr    (max_wr),
      .max_sel   (max_sel),
      .max_wdata (max_wdata),
      .pix_in    (pix_in),
      .lut_q     (lut_q),
      .pix_out   (pix_out),
      .max_flat  (max_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= pix_vld_in;
   end

   assign pix_vld_out = vld_q;
   assign legacy_en   = !(ctrl_q.ainc || ctrl_q.split);

endmodule

// File: rtl/prec_gamma_lut_chk.sv
module prec_gamma_lut_chk #(
   parameter int unsigned CW = 10,
   parameter int unsigned AW = 8,
   parameter int unsigned MW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 idx_wr,
   input logic [15:0]          idx_wdata,
   input logic                 dat_wr,
   input logic                 max_wr,
   input logic                 pix_vld_in,
   input logic [3*(CW+1)-1:0]  pix_in,
   input logic                 pix_vld_out,
   input logic [3*MW-1:0]      pix_out,
   input logic                 legacy_en,
   input logic [AW-1:0]        idx_q,
   input logic                 ainc_q,
   input logic                 split_q,
   input logic [3*MW-1:0]      max_flat
);

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && ainc_q && !split_q && !idx_wr |=> idx_q == AW'($past(idx_q) + 1'b1));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && !ainc_q && !idx_wr |=> $stable(idx_q));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && ainc_q && !split_q && !idx_wr && (&idx_q) |=> idx_q == '0);

   assert_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr && ainc_q && split_q && !idx_wr |=> idx_q[AW-1] == $past(idx_q[AW-1]));

   assert_legacy_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr && (idx_wdata[15:14] == 2'b00) |=> legacy_en);

   assert_legacy_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr && (idx_wdata[15:14] != 2'b00) |=> !legacy_en);

   assert_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_in[3*(CW+1)-1] && !max_wr |=> pix_out[3*MW-1 -: MW] == $past(max_flat[3*MW-1 -: MW]));

   assert_vld_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_in |=> pix_vld_out);

   assert_vld_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld_in |=> !pix_vld_out);

endmodule

bind prec_gamma_lut prec_gamma_lut_chk #(.CW(CW), .AW(AW), .MW(MW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .idx_wr      (idx_wr),
   .idx_wdata   (idx_wdata),
   .dat_wr      (dat_wr),
   .max_wr      (max_wr),
   .pix_vld_in  (pix_vld_in),
   .pix_in      (pix_in),
   .pix_vld_out (pix_vld_out),
   .pix_out     (pix_out),
   .legacy_en   (legacy_en),
   .idx_q       (idx_q),
   .ainc_q      (ctrl_q.ainc),
   .split_q     (ctrl_q.split),
   .max_flat    (max_flat)
);

// File: tb/prec_gamma_lut_test.sv
module prec_gamma_lut_test;

   localparam int CW = 10;
   localparam int AW = 8;
   localparam int MW = 16;
   localparam int DEPTH = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_wr = 1'b0;
   logic [15:0]   idx_wdata = '0;
   logic          dat_wr = 1'b0;
   logic [29:0]   dat_wdata = '0;
   logic          max_wr = 1'b0;
   logic [1:0]    max_sel = '0;
   logic [15:0]   max_wdata = '0;
   logic          pix_vld_in = 1'b0;
   logic [32:0]   pix_in = '0;
   logic          pix_vld_out;
   logic [47:0]   pix_out;
   logic          legacy_en;

   int n_checks = 0;
   int n_fail   = 0;

   logic [29:0] model [DEPTH];
   logic [15:0] mmax [3];
   logic [7:0]  midx;
   bit          mainc;
   bit          msplit;

   always #5 clk = ~clk;

   prec_gamma_lut #(.CW(CW), .AW(AW), .MW(MW)) uut (
      .clk(clk), .rst_n(rst_n),
      .idx_wr(idx_wr), .idx_wdata(idx_wdata),
      .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .max_wr(max_wr), .max_sel(max_sel), .max_wdata(max_wdata),
      .pix_vld_in(pix_vld_in), .pix_in(pix_in),
      .pix_vld_out(pix_vld_out), .pix_out(pix_out),
      .legacy_en(legacy_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idx_write(input logic [15:0] v);
      @(negedge clk);
      idx_wr = 1'b1; idx_wdata = v;
      @(negedge clk);
      idx_wr = 1'b0;
      midx = v[7:0]; mainc = v[15]; msplit = v[14];
   endtask

   task automatic dat_write(input logic [29:0] w);
      @(negedge clk);
      dat_wr = 1'b1; dat_wdata = w;
      @(negedge clk);
      dat_wr = 1'b0;
      model[midx] = w;
      if (mainc) midx = msplit ? {midx[7], midx[6:0] + 7'd1} : midx + 8'd1;
   endtask

   task automatic max_write(input logic [1:0] s, input logic [15:0] v);
      @(negedge clk);
      max_wr = 1'b1; max_sel = s; max_wdata = v;
      @(negedge clk);
      max_wr = 1'b0;
      if (s != 2'd3) mmax[s] = v;
   endtask

   function automatic logic [15:0] exp_ch(input int c, input logic [10:0] v);
      int a;
      if (v[10]) return mmax[c];
      a = msplit ? (128 + int'(v[9:0] >> 3)) : int'(v[9:0] >> 2);
      return {model[a][c*10 +: 10], 6'b0};
   endfunction

   task automatic look(input logic [10:0] r, input logic [10:0] g,
                       input logic [10:0] b, input string req);
      logic [15:0] er, eg, eb;
      er = exp_ch(2, r); eg = exp_ch(1, g); eb = exp_ch(0, b);
      @(negedge clk);
      pix_in = {r, g, b}; pix_vld_in = 1'b1;
      @(negedge clk);
      pix_vld_in = 1'b0;
      chk(pix_out[47:32] == er, req, "red", pix_out[47:32], er);
      chk(pix_out[31:16] == eg, req, "green", pix_out[31:16], eg);
      chk(pix_out[15:0] == eb, req, "blue", pix_out[15:0], eb);
   endtask

   task automatic t_reset;
      chk(legacy_en == 1'b1, "R1", "legacy after reset", legacy_en, 1);
      chk(pix_vld_out == 1'b0, "R1", "vld after reset", pix_vld_out, 0);
      look(11'd0, 11'd512, 11'd1023, "R1");
      look(11'd4, 11'd700, 11'd333, "R1");
      look(11'h400, 11'h400, 11'h7FF, "R1");
   endtask

   task automatic t_autoinc;
      idx_write(16'h8000 | 16'd10);
      chk(legacy_en == 1'b0, "R9", "legacy with auto-advance", legacy_en, 0);
      dat_write({10'h3A5, 10'h05A, 10'h111});
      dat_write({10'h001, 10'h3FF, 10'h200});
      dat_write({10'h2AA, 10'h155, 10'h0F0});
      look(11'd40, 11'd44, 11'd48, "R3");
      look(11'd43, 11'd46, 11'd51, "R2");
      look(11'd52, 11'd52, 11'd52, "R8");
   endtask

   task automatic t_noinc;
      idx_write(16'd20);
      chk(legacy_en == 1'b1, "R9", "legacy with flags clear", legacy_en, 1);
      dat_write({10'h123, 10'h234, 10'h345});
      dat_write({10'h0AB, 10'h0CD, 10'h0EF});
      look(11'd80, 11'd81, 11'd82, "R4");
      look(11'd84, 11'd85, 11'd86, "R4");
   endtask

   task automatic t_wrap;
      idx_write(16'h8000 | 16'd254);
      dat_write({10'h311, 10'h322, 10'h333});
      dat_write({10'h344, 10'h355, 10'h366});
      dat_write({10'h077, 10'h088, 10'h099});
      look(11'd1016, 11'd1020, 11'd1023, "R5");
      look(11'd0, 11'd1, 11'd3, "R5");
   endtask

   task automatic t_split;
      idx_write(16'hC000 | 16'd126);
      chk(legacy_en == 1'b0, "R9", "legacy with split", legacy_en, 0);
      dat_write({10'h101, 10'h102, 10'h103});
      dat_write({10'h104, 10'h105, 10'h106});
      dat_write({10'h1F1, 10'h1F2, 10'h1F3});
      idx_write(16'hC000 | 16'd254);
      dat_write({10'h201, 10'h202, 10'h203});
      dat_write({10'h204, 10'h205, 10'h206});
      dat_write({10'h2E1, 10'h2E2, 10'h2E3});
      look(11'd0, 11'd7, 11'd5, "R6");
      look(11'd1016, 11'd1023, 11'd1008, "R7");
      look(11'd500, 11'd8, 11'd1015, "R7");
      idx_write(16'd0);
      chk(legacy_en == 1'b1, "R9", "legacy after zero write", legacy_en, 1);
      look(11'd0, 11'd504, 11'd508, "R6");
      look(11'd512, 11'd3, 11'd1023, "R8");
   endtask

   task automatic t_max;
      max_write(2'd2, 16'h1234);
      max_write(2'd1, 16'hABCD);
      max_write(2'd0, 16'h0F0F);
      max_write(2'd3, 16'h5555);
      look(11'h400, 11'd100, 11'd200, "R10");
      look(11'd300, 11'h5FF, 11'd9, "R10");
      look(11'h7FF, 11'h400, 11'h400, "R11");
   endtask

   task automatic t_latency;
      @(negedge clk);
      pix_in = {11'd4, 11'd4, 11'd4}; pix_vld_in = 1'b1;
      #1;
      chk(pix_vld_out == 1'b0, "R12", "vld before edge", pix_vld_out, 0);
      @(negedge clk);
      pix_vld_in = 1'b0;
      chk(pix_vld_out == 1'b1, "R12", "vld one cycle later", pix_vld_out, 1);
      chk(pix_out[47:32] == {model[1][29:20], 6'b0}, "R12", "data one cycle later",
          pix_out[47:32], {model[1][29:20], 6'b0});
      @(negedge clk);
      chk(pix_vld_out == 1'b0, "R12", "vld drop", pix_vld_out, 0);
   endtask

   task automatic t_collide;
      logic [15:0] old_r;
      idx_write(16'd40);
      old_r = {model[40][29:20], 6'b0};
      @(negedge clk);
      dat_wr = 1'b1; dat_wdata = {10'h3C3, 10'h3C3, 10'h3C3};
      pix_in = {11'd160, 11'd160, 11'd160}; pix_vld_in = 1'b1;
      @(negedge clk);
      dat_wr = 1'b0; pix_vld_in = 1'b0;
      chk(pix_out[47:32] == old_r, "R13", "old data on collision", pix_out[47:32], old_r);
      model[40] = {10'h3C3, 10'h3C3, 10'h3C3};
      look(11'd160, 11'd161, 11'd163, "R13");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         model[i] = {3{10'((i * 1023) / (DEPTH - 1))}};
      end
      for (int c = 0; c < 3; c++) mmax[c] = 16'hFFFF;
      midx = '0; mainc = 1'b0; msplit = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_autoinc();
      t_noinc();
      t_wrap();
      t_split();
      t_max();
      t_latency();
      t_collide();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule